// File: doc/BRIEF.md
# Signed-Digit Decimal Partial Product Generator

This combinational block produces every partial product of a parallel decimal multiplication in a single pass. It accepts an `NDIG`-digit BCD multiplicand and an `NDIG`-digit BCD multiplier. Each multiplier digit is rewritten as a signed digit between -5 and +5, which gives one extra top position. For each position the block then picks one of the multiplicand multiples 0, X, 2X, 3X, 4X or 5X. A negative digit selects the multiple of its magnitude and flips every bit of it.

Inside the block the multiples use two weighted digit codes: 4221 and 5211. The doubled and quintupled forms come from moving the whole bit vector left, with no carry chain involved. 4X is the double of 2X. Only 3X needs a true decimal addition, namely X + 2X. Every partial product leaves the block in the 4221 code, `NDIG+1` digits wide. Each one has a sign flag and a hot-one bit. The reduction tree downstream adds the hot-one bit at the lowest digit of that row, which completes the ten's complement of a negative row.

Top module: `sdr_pp_gen`

## Requirements
- R1: For multiplier digit y_i (BCD, bits [4i+3:4i] of `mult_y`, value 0..9), the transfer is t_i = 1 when y_i >= 5. The recoded digit is s_i = y_i - 10*t_i + t_(i-1), with t_(-1) = 0. Position `NDIG` carries s_NDIG = t_(NDIG-1).
- R2: Every recoded digit lies in -5..+5. The top position (index `NDIG`) never carries a negative flag.
- R3: When s_i > 0, partial product i holds |s_i|*X. It occupies bits [i*PPW +: PPW] of `pp_bits`, with PPW = 4*(NDIG+1). It is written as NDIG+1 digits in 4221 code: digit d sits at bits [4d+3:4d], and the bit weights from bit 3 down to bit 0 are 4, 2, 2, 1.
- R4: When s_i < 0, `pp_neg[i]` is 1 and partial product i is the bitwise inverse of the 4221 form of |s_i|*X. Read in 4221, it therefore equals 10^(NDIG+1) - 1 - |s_i|*X.
- R5: `pp_hot[i]` is 1 exactly when s_i < 0.
- R6: When s_i = 0, partial product i is all zero bits and both `pp_neg[i]` and `pp_hot[i]` are 0.
- R7: Take each row's signed value: the 4221 value when `pp_neg` is 0, and minus the magnitude given by R4 when `pp_neg` is 1. The sum over i of these values times 10^i equals X*Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mult_x | input | 4*NDIG | Multiplicand, BCD, digit i at bits [4i+3:4i] |
| mult_y | input | 4*NDIG | Multiplier, BCD, digit i at bits [4i+3:4i] |
| pp_bits | output | (NDIG+1)*4*(NDIG+1) | Partial products in 4221 code, row i at [i*PPW +: PPW] |
| pp_neg | output | NDIG+1 | Row i represents a negative multiple |
| pp_hot | output | NDIG+1 | Hot-one bit to be added at the lowest digit of row i |

## Verification
The assertions assume that every 4-bit group of both operands is a legal BCD digit, 0 through 9. The range check on recoded digits and the doubling relations between the internal multiples only make sense under that assumption. The stimulus honours it by always building operands from integer values split into decimal digits, never from raw bit patterns. It still covers the extremes that stress the transfer chain: all nines, all zeros, all fives, and alternating fours and fives, along with random values.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    // Value 0..9 to 4221 code (weights 4,2,2,1).
    function automatic logic [3:0] enc4221(input logic [3:0] v);
        logic [3:0] c;
        case (v)
            4'd0: c = 4'b0000;
            4'd1: c = 4'b0001;
            4'd2: c = 4'b0010;
            4'd3: c = 4'b0011;
            4'd4: c = 4'b1000;
            4'd5: c = 4'b1001;
            4'd6: c = 4'b1010;
            4'd7: c = 4'b1011;
            4'd8: c = 4'b1110;
            default: c = 4'b1111;
        endcase
        return c;
    endfunction

    // Value 0..9 to 5211 code (weights 5,2,1,1).
    function automatic logic [3:0] enc5211(input logic [3:0] v);
        logic [3:0] c;
        case (v)
            4'd0: c = 4'b0000;
            4'd1: c = 4'b0001;
            4'd2: c = 4'b0100;
            4'd3: c = 4'b0101;
            4'd4: c = 4'b0111;
            4'd5: c = 4'b1000;
            4'd6: c = 4'b1001;
            4'd7: c = 4'b1100;
            4'd8: c = 4'b1101;
            default: c = 4'b1111;
        endcase
        return c;
    endfunction

    function automatic logic [3:0] dec4221(input logic [3:0] c);
        return {1'b0, c[3], 2'b00} + {2'b00, c[2], 1'b0} + {2'b00, c[1], 1'b0} + {3'b000, c[0]};
    endfunction

    function automatic logic [3:0] dec5211(input logic [3:0] c);
        return ({3'b000, c[3]} * 4'd5) + {2'b00, c[2], 1'b0} + {3'b000, c[1]} + {3'b000, c[0]};
    endfunction

endpackage

// File: rtl/sdr_recoder.sv
module sdr_recoder #(
    parameter int NDIG = 8,
    localparam int NW = NDIG + 1
) (
    input  logic [4*NDIG-1:0]  y_bcd,
    output logic [NW-1:0][2:0] sd_mag,
    output logic [NW-1:0]      sd_neg
);
    logic [NDIG:0] xfer;   // xfer[i+1] is the transfer out of digit i

    assign xfer[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < NDIG; gi++) begin : g_dig
            logic [3:0] yd;
            logic [3:0] mag_d;
            assign yd = y_bcd[4*gi +: 4];
            assign xfer[gi+1] = (yd >= 4'd5);
            always_comb begin
                if (yd >= 4'd5) begin
                    // y - 10 + tin is in -5..0; magnitude is 10 - y - tin
                    mag_d = 4'd10 - yd - {3'b000, xfer[gi]};
                    sd_neg[gi] = (mag_d != 4'd0);
                end else begin
                    mag_d = yd + {3'b000, xfer[gi]};
                    sd_neg[gi] = 1'b0;
                end
                sd_mag[gi] = mag_d[2:0];
            end
        end
    endgenerate

    assign sd_mag[NDIG] = {2'b00, xfer[NDIG]};
    assign sd_neg[NDIG] = 1'b0;

endmodule

// File: rtl/sdr_multiples.sv
module sdr_multiples
    import sdr_pkg::*;
#(
    parameter int NDIG = 8,
    localparam int NW = NDIG + 1,
    localparam int W  = 4 * NW
) (
    input  logic [4*NDIG-1:0] x_bcd,
    output logic [W-1:0]      mul1,
    output logic [W-1:0]      mul2,
    output logic [W-1:0]      mul3,
    output logic [W-1:0]      mul4,
    output logic [W-1:0]      mul5
);
    logic [W-1:0] x_4221;
    logic [W-1:0] x_5211;
    logic [W-1:0] m2_5211;
    logic [W-1:0] m5_5211;

    genvar gi;
    generate
        for (gi = 0; gi < NDIG; gi++) begin : g_enc
            assign x_4221[4*gi +: 4] = enc4221(x_bcd[4*gi +: 4]);
            assign x_5211[4*gi +: 4] = enc5211(x_bcd[4*gi +: 4]);
        end
    endgenerate
    assign x_4221[W-1 -: 4] = 4'b0000;
    assign x_5211[W-1 -: 4] = 4'b0000;

    // 5211 vector moved one bit left reads as twice the value in 4221
    assign mul2 = {x_5211[W-2:0], 1'b0};

    // 4221 vector moved three bits left reads as five times the value in 5211
    assign m5_5211 = {x_4221[W-4:0], 3'b000};

    generate
        for (gi = 0; gi < NW; gi++) begin : g_rec
            assign m2_5211[4*gi +: 4] = enc5211(dec4221(mul2[4*gi +: 4]));
            assign mul5[4*gi +: 4]    = enc4221(dec5211(m5_5211[4*gi +: 4]));
        end
    endgenerate

    assign mul1 = x_4221;
    assign mul4 = {m2_5211[W-2:0], 1'b0};

    // 3X = X + 2X through a ripple decimal adder
    always_comb begin
        logic       cy;
        logic [4:0] s;
        cy = 1'b0;
        mul3 = '0;
        for (int d = 0; d < NW; d++) begin
            s = {1'b0, dec4221(x_4221[4*d +: 4])} + {1'b0, dec4221(mul2[4*d +: 4])} + {4'b0000, cy};
            if (s >= 5'd10) begin
                s  = s - 5'd10;
                cy = 1'b1;
            end else begin
                cy = 1'b0;
            end
            mul3[4*d +: 4] = enc4221(s[3:0]);
        end
    end

endmodule

// File: rtl/sdr_pp_lane.sv
module sdr_pp_lane #(
    parameter int NDIG = 8,
    localparam int W = 4 * (NDIG + 1)
) (
    input  logic [2:0]   mag,
    input  logic         neg,
    input  logic [W-1:0] mul1,
    input  logic [W-1:0] mul2,
    input  logic [W-1:0] mul3,
    input  logic [W-1:0] mul4,
    input  logic [W-1:0] mul5,
    output logic [W-1:0] pp,
    output logic         pp_n,
    output logic         pp_h
);
    logic [W-1:0] sel_d;

    always_comb begin
        case (mag)
            3'd1:    sel_d = mul1;
            3'd2:    sel_d = mul2;
            3'd3:    sel_d = mul3;
            3'd4:    sel_d = mul4;
            3'd5:    sel_d = mul5;
            default: sel_d = '0;
        endcase
        pp   = neg ? ~sel_d : sel_d;
        pp_n = neg;
        pp_h = neg;
    end

endmodule

// File: rtl/sdr_pp_gen.sv
module sdr_pp_gen #(
    parameter int NDIG = 8,
    localparam int NW  = NDIG + 1,
    localparam int PPW = 4 * NW
) (
    input  logic [4*NDIG-1:0]  mult_x,
    input  logic [4*NDIG-1:0]  mult_y,
    output logic [NW*PPW-1:0]  pp_bits,
    output logic [NW-1:0]      pp_neg,
    output logic [NW-1:0]      pp_hot
);
    logic [NW-1:0][2:0] sd_mag;
    logic [NW-1:0]      sd_neg;
    logic [PPW-1:0]     mul1, mul2, mul3, mul4, mul5;

    sdr_recoder #(.NDIG(NDIG)) u_rec (
        .y_bcd  (mult_y),
        .sd_mag (sd_mag),
        .sd_neg (sd_neg)
    );

    sdr_multiples #(.NDIG(NDIG)) u_mul (
        .x_bcd (mult_x),
        .mul1  (mul1),
        .mul2  (mul2),
        .mul3  (mul3),
        .mul4  (mul4),
        .mul5  (mul5)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NW; gi++) begin : g_lane
            sdr_pp_lane #(.NDIG(NDIG)) u_lane (
                .mag  (sd_mag[gi]),
                .neg  (sd_neg[gi]),
                .mul1 (mul1),
                .mul2 (mul2),
                .mul3 (mul3),
                .mul4 (mul4),
                .mul5 (mul5),
                .pp   (pp_bits[gi*PPW +: PPW]),
                .pp_n (pp_neg[gi]),
                .pp_h (pp_hot[gi])
            );
        end
    endgenerate

endmodule

// File: rtl/sdr_pp_gen_chk.sv
module sdr_pp_gen_chk
    import sdr_pkg::*;
#(
    parameter int NDIG = 8,
    localparam int NW  = NDIG + 1,
    localparam int PPW = 4 * NW
) (
    input logic [4*NDIG-1:0] mult_x,
    input logic [NW*PPW-1:0] pp_bits,
    input logic [NW-1:0]     pp_neg,
    input logic [NW-1:0]     pp_hot,
    input logic [NW-1:0][2:0] sd_mag,
    input logic [NW-1:0]     sd_neg,
    input logic [PPW-1:0]    mul2,
    input logic [PPW-1:0]    mul4
);
    function automatic longint val4221(input logic [PPW-1:0] v);
        longint acc = 0;
        for (int d = NW - 1; d >= 0; d--) acc = acc * 10 + longint'(dec4221(v[4*d +: 4]));
        return acc;
    endfunction

    function automatic longint valbcd(input logic [4*NDIG-1:0] v);
        longint acc = 0;
        for (int d = NDIG - 1; d >= 0; d--) acc = acc * 10 + longint'(v[4*d +: 4]);
        return acc;
    endfunction

    always_comb begin
        assert_top_pos_R2: assert (sd_neg[NDIG] == 1'b0);
        assert_dbl_R3: assert (val4221(mul2) == 2 * valbcd(mult_x));
        assert_quad_R3: assert (val4221(mul4) == 2 * val4221(mul2));
        for (int i = 0; i < NW; i++) begin
            assert_mag_range_R2: assert (sd_mag[i] <= 3'd5);
            assert_neg_flag_R4: assert (pp_neg[i] == sd_neg[i]);
            assert_hot_flag_R5: assert (pp_hot[i] == sd_neg[i]);
            if (sd_mag[i] == 3'd0) begin
                assert_zero_row_R6: assert (pp_bits[i*PPW +: PPW] == '0 && !pp_neg[i]);
            end
        end
    end

endmodule

bind sdr_pp_gen sdr_pp_gen_chk #(.NDIG(NDIG)) u_chk (
    .mult_x  (mult_x),
    .pp_bits (pp_bits),
    .pp_neg  (pp_neg),
    .pp_hot  (pp_hot),
    .sd_mag  (sd_mag),
    .sd_neg  (sd_neg),
    .mul2    (mul2),
    .mul4    (mul4)
);

// File: tb/test_sdr_pp_gen.sv
`timescale 1ns/1ps
module test_sdr_pp_gen;
    localparam int NDIG = 8;
    localparam int NW   = NDIG + 1;
    localparam int PPW  = 4 * NW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4*NDIG-1:0] mult_x = '0;
    logic [4*NDIG-1:0] mult_y = '0;
    logic [NW*PPW-1:0] pp_bits;
    logic [NW-1:0]     pp_neg;
    logic [NW-1:0]     pp_hot;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdr_pp_gen #(.NDIG(NDIG)) i_sdr_pp_gen (
        .mult_x  (mult_x),
        .mult_y  (mult_y),
        .pp_bits (pp_bits),
        .pp_neg  (pp_neg),
        .pp_hot  (pp_hot)
    );

    function automatic logic [4*NDIG-1:0] to_bcd(input longint v);
        logic [4*NDIG-1:0] r = '0;
        longint t = v;
        for (int d = 0; d < NDIG; d++) begin
            r[4*d +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic longint row_val(input logic [PPW-1:0] v);
        longint acc = 0;
        for (int d = NW - 1; d >= 0; d--)
            acc = acc * 10 + 4 * longint'(v[4*d+3]) + 2 * longint'(v[4*d+2])
                  + 2 * longint'(v[4*d+1]) + longint'(v[4*d]);
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (x=%h y=%h)", req, act, exp, mult_x, mult_y);
        end
    endtask

    task automatic run_vec(input longint xv, input longint yv);
        longint sd [NW];
        longint tin;
        longint p10;
        longint full;
        longint sum;
        @(posedge clk);
        #1;
        mult_x = to_bcd(xv);
        mult_y = to_bcd(yv);
        @(negedge clk);
        // reference recoding (R1)
        tin = 0;
        p10 = 1;
        for (int i = 0; i < NDIG; i++) begin
            longint yd = (yv / p10) % 10;
            longint t  = (yd >= 5) ? 1 : 0;
            sd[i] = yd - 10 * t + tin;
            tin = t;
            p10 = p10 * 10;
        end
        sd[NDIG] = tin;
        full = 1;
        for (int d = 0; d < NW; d++) full = full * 10;
        sum = 0;
        p10 = 1;
        for (int i = 0; i < NW; i++) begin
            logic [PPW-1:0] row = pp_bits[i*PPW +: PPW];
            longint d   = row_val(row);
            longint mag = (sd[i] < 0) ? -sd[i] : sd[i];
            bit     en  = (sd[i] < 0);
            // R1/R4: sign flag follows the recoded digit
            check(pp_neg[i] == en, "R4 neg flag", longint'(pp_neg[i]), longint'(en));
            // R5: hot-one bit
            check(pp_hot[i] == en, "R5 hot bit", longint'(pp_hot[i]), longint'(en));
            if (i == NDIG) check(!pp_neg[i], "R2 top row positive", longint'(pp_neg[i]), 0);
            if (sd[i] == 0)
                check(row == '0, "R6 zero row", d, 0);
            else if (en)
                check(full - 1 - d == mag * xv, "R4 inverted multiple", full - 1 - d, mag * xv);
            else
                check(d == mag * xv, "R3 positive multiple", d, mag * xv);
            sum += (pp_neg[i] ? -(full - 1 - d) : d) * p10;
            p10 = p10 * 10;
        end
        check(sum == xv * yv, "R7 weighted sum", sum, xv * yv);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        longint nines = 99999999;
        longint fives = 55555555;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: zero operands give zero rows (R6)
        for (int i = 0; i < NW; i++)
            check(pp_bits[i*PPW +: PPW] == '0 && !pp_neg[i] && !pp_hot[i], "R6 reset rows", 0, 0);
        rst_n = 1'b1;
        run_vec(0, 0);
        run_vec(nines, nines);
        run_vec(nines, 0);
        run_vec(0, nines);
        run_vec(fives, fives);
        run_vec(nines, fives);
        run_vec(45454545, 54545454);
        run_vec(12345678, 98765432);
        run_vec(1, 5);
        run_vec(7, 99999995);
        for (int n = 0; n < 300; n++)
            run_vec(longint'($urandom_range(0, 99999999)), longint'($urandom_range(0, 99999999)));
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule